// File: doc/BRIEF.md
# Load/Store Alignment Exception Checker

This block sits beside the load/store path and looks at every decoded memory operation once. From the operation's class, effective address, operand size, the page and data-cache attributes, a precomputed segment-crossing flag and the little-endian mode bit, it decides whether the access must be replaced by an alignment exception. The verdict is registered: one cycle after a faulting operation is presented, the block raises an exception request together with the vector offset 0x600 and the effective address that caused it.

The request stays up until the exception unit acknowledges it. While a request is pending, further operations are not examined, so the first fault wins. An acknowledge in the same cycle as a new faulting operation retires the old request and captures the new one. Operations that match no rule pass with no exception, and the checker never stalls the pipeline.

The rules depend on the instruction class. Floating-point, multiple-word and reservation operations need word alignment. External-control reads and writes need natural alignment for their size. Cache-block-zero depends only on cache attributes. Multiple and string operations are refused in little-endian mode. An ordinary misaligned access is never refused for its alignment, in either byte order.

Top module: `ls_align_chk`

## Requirements
- R1: After reset, exc_req is 0, exc_vec is 0 and exc_ea is 0.
- R2: A floating-point operation (op_class 1) faults when op_direct_store is 1 or op_ea[1:0] is not 00.
- R3: A multiple-word operation (op_class 2) and a reservation word operation (op_class 4) fault when op_ea[1:0] is not 00.
- R4: A plain (op_class 0), multiple-word (op_class 2) or string (op_class 3) operation faults when op_seg_tflip is 1. The flag has no effect on the other classes.
- R5: A cache-block-zero operation (op_class 5) faults when any of op_wthru, op_cinhib, dc_absent or dc_wthru is 1, whatever its address.
- R6: An external-control operation (op_class 6) faults when op_ea is not a multiple of its operand size. The size is 2**op_size bytes, with op_size 0..3 giving 1, 2, 4 or 8 bytes.
- R7: A multiple-word or string operation faults when op_le_mode is 1, even at an aligned address.
- R8: A misaligned plain operation never faults in either byte order, and a misaligned string operation does not fault when op_le_mode is 0 and op_seg_tflip is 0.
- R9: A fault on an operation accepted at clock edge N raises exc_req after edge N. From that point exc_vec reads 0x600 and exc_ea holds that operation's op_ea. When exc_req is 0, exc_vec reads 0.
- R10: While exc_req is 1 and exc_ack is 0, the request and exc_ea stay unchanged, and new faulting operations are ignored. When exc_ack is 1, the request clears, unless a faulting operation is presented in the same cycle; that operation is then captured.
- R11: An operation presented with op_valid 0 raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_class | input | 3 | 0 plain, 1 float, 2 multiple, 3 string, 4 reservation, 5 block zero, 6 external control |
| op_ea | input | AW | Effective address |
| op_size | input | 2 | log2 of operand size in bytes |
| op_le_mode | input | 1 | Little-endian mode |
| op_seg_tflip | input | 1 | Access crosses a segment boundary where the direct-store bit changes |
| op_direct_store | input | 1 | Operand lies in a direct-store segment |
| op_wthru | input | 1 | Target page is write-through |
| op_cinhib | input | 1 | Target page is caching-inhibited |
| dc_absent | input | 1 | No data cache present |
| dc_wthru | input | 1 | Data cache operates write-through |
| exc_ack | input | 1 | Exception request accepted |
| exc_req | output | 1 | Alignment exception request |
| exc_vec | output | VW | Vector offset (0x600 while requesting) |
| exc_ea | output | AW | Faulting effective address |

## Verification
The case that is hardest to reach from the ports is a second fault that arrives while the first is still pending. It gets harder when that second fault lands in the same cycle as the acknowledge. The stimulus raises a reservation fault and leaves it unacknowledged. It then presents a floating-point fault and checks that the first address is held. Next it asserts the acknowledge together with a third faulting operation, which must be the one captured. Every other rule is exercised by a fault or no-fault pair that differs in a single attribute or address bit.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
    typedef enum logic [2:0] {
        CLS_PLAIN   = 3'd0,
        CLS_FLOAT   = 3'd1,
        CLS_MULTI   = 3'd2,
        CLS_STRING  = 3'd3,
        CLS_RESERVE = 3'd4,
        CLS_BZERO   = 3'd5,
        CLS_EXTCTL  = 3'd6
    } op_cls_e;

    typedef struct packed {
        logic le_mode;
        logic seg_tflip;
        logic direct_store;
        logic wthru;
        logic cinhib;
        logic dc_absent;
        logic dc_wthru;
    } op_attr_t;
endpackage

// File: rtl/ls_align_rules.sv
module ls_align_rules
    import ls_align_pkg::*;
(
    input  logic [2:0] cls,
    input  logic [2:0] ea_lo,
    input  logic [1:0] size,
    input  op_attr_t   attr,
    output logic       fault
);
    logic [2:0] size_mask;
    logic       word_mis;
    logic       nat_mis;
    logic       tflip_cls;
    logic       le_cls;
    logic       class_fault;

    always_comb begin
        case (size)
            2'd0:    size_mask = 3'b000;
            2'd1:    size_mask = 3'b001;
            2'd2:    size_mask = 3'b011;
            default: size_mask = 3'b111;
        endcase
        word_mis  = |ea_lo[1:0];
        nat_mis   = |(ea_lo & size_mask);
        tflip_cls = (cls == CLS_PLAIN) || (cls == CLS_MULTI) || (cls == CLS_STRING);
        le_cls    = (cls == CLS_MULTI) || (cls == CLS_STRING);
        case (cls)
            CLS_FLOAT:   class_fault = attr.direct_store | word_mis;
            CLS_MULTI:   class_fault = word_mis;
            CLS_RESERVE: class_fault = word_mis;
            CLS_BZERO:   class_fault = attr.wthru | attr.cinhib | attr.dc_absent | attr.dc_wthru;
            CLS_EXTCTL:  class_fault = nat_mis;
            default:     class_fault = 1'b0;
        endcase
        fault = class_fault | (tflip_cls & attr.seg_tflip) | (le_cls & attr.le_mode);
    end
endmodule

// File: rtl/ls_align_hold.sv
module ls_align_hold #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] ea_in,
    input  logic          ack,
    output logic          req,
    output logic [AW-1:0] ea_out
);
    typedef struct packed {
        logic          req;
        logic [AW-1:0] ea;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req && !ack) begin
            st_d = st_q;
        end else if (take) begin
            st_d.req = 1'b1;
            st_d.ea  = ea_in;
        end else begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req    = st_q.req;
    assign ea_out = st_q.ea;
endmodule

// File: rtl/ls_align_chk.sv
module ls_align_chk
    import ls_align_pkg::*;
#(
    parameter int              AW  = 32,
    parameter int              VW  = 12,
    parameter logic [VW-1:0]   VEC = 12'h600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_class,
    input  logic [AW-1:0] op_ea,
    input  logic [1:0]    op_size,
    input  logic          op_le_mode,
    input  logic          op_seg_tflip,
    input  logic          op_direct_store,
    input  logic          op_wthru,
    input  logic          op_cinhib,
    input  logic          dc_absent,
    input  logic          dc_wthru,
    input  logic          exc_ack,
    output logic          exc_req,
    output logic [VW-1:0] exc_vec,
    output logic [AW-1:0] exc_ea
);
    op_attr_t attr;
    logic     fault;

    always_comb begin
        attr.le_mode      = op_le_mode;
        attr.seg_tflip    = op_seg_tflip;
        attr.direct_store = op_direct_store;
        attr.wthru        = op_wthru;
        attr.cinhib       = op_cinhib;
        attr.dc_absent    = dc_absent;
        attr.dc_wthru     = dc_wthru;
    end

    ls_align_rules u_rules (
        .cls   (op_class),
        .ea_lo (op_ea[2:0]),
        .size  (op_size),
        .attr  (attr),
        .fault (fault)
    );

    ls_align_hold #(.AW(AW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (op_valid & fault),
        .ea_in  (op_ea),
        .ack    (exc_ack),
        .req    (exc_req),
        .ea_out (exc_ea)
    );

    assign exc_vec = exc_req ? VEC : '0;
endmodule

// File: rtl/ls_align_chk_sva.sv
module ls_align_chk_sva #(
    parameter int              AW  = 32,
    parameter int              VW  = 12,
    parameter logic [VW-1:0]   VEC = 12'h600
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_class,
    input logic [AW-1:0] op_ea,
    input logic [1:0]    op_size,
    input logic          op_le_mode,
    input logic          op_seg_tflip,
    input logic          op_direct_store,
    input logic          op_wthru,
    input logic          op_cinhib,
    input logic          dc_absent,
    input logic          dc_wthru,
    input logic          exc_ack,
    input logic          exc_req,
    input logic [VW-1:0] exc_vec,
    input logic [AW-1:0] exc_ea
);
    logic free;
    assign free = !exc_req || exc_ack;

    AST_VEC_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_vec == VEC); // R9

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !exc_ack |=> exc_req && $stable(exc_ea)); // R10

    AST_RESERVE_MIS: assert property (@(posedge clk) disable iff (!rst_n)
        free && op_valid && op_class == 3'd4 && op_ea[1:0] != 2'b00
        |=> exc_req && exc_ea == $past(op_ea)); // R3

    AST_LE_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        free && op_valid && op_class == 3'd2 && op_le_mode |=> exc_req); // R7

    AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        free && op_valid && op_class == 3'd0 && !op_seg_tflip |=> !exc_req); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        free && !op_valid |=> !exc_req); // R11

    AST_BZERO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        free && op_valid && op_class == 3'd5 && (op_wthru || op_cinhib || dc_absent || dc_wthru)
        |=> exc_req); // R5
endmodule

bind ls_align_chk ls_align_chk_sva #(.AW(AW), .VW(VW), .VEC(VEC)) u_sva (.*);

// File: tb/ls_align_chk_bench.sv
module ls_align_chk_bench;
    localparam int AW = 32;
    localparam int VW = 12;

    typedef struct {
        logic          req;
        logic [AW-1:0] ea;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_class = '0;
    logic [AW-1:0] op_ea = '0;
    logic [1:0]    op_size = 2'd2;
    logic [6:0]    attr = '0;
    logic          exc_ack = 1'b0;
    logic          exc_req;
    logic [VW-1:0] exc_vec;
    logic [AW-1:0] exc_ea;

    int            n_cmp = 0;
    int            n_bad = 0;
    exp_t          q[$];
    logic          m_req = 1'b0;
    logic [AW-1:0] m_ea = '0;
    logic          done = 1'b0;

    always #4 clk = ~clk;

    ls_align_chk u_ls_align_chk (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_ea(op_ea), .op_size(op_size),
        .op_le_mode(attr[6]), .op_seg_tflip(attr[5]), .op_direct_store(attr[4]),
        .op_wthru(attr[3]), .op_cinhib(attr[2]), .dc_absent(attr[1]), .dc_wthru(attr[0]),
        .exc_ack(exc_ack), .exc_req(exc_req), .exc_vec(exc_vec), .exc_ea(exc_ea)
    );

    // one cycle of stimulus; flt is the rule verdict stated by the caller
    task automatic drive(input logic v, input logic [2:0] cls, input logic [AW-1:0] ea,
                         input logic [1:0] sz, input logic [6:0] at, input logic ack,
                         input logic flt, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = v; op_class = cls; op_ea = ea; op_size = sz; attr = at; exc_ack = ack;
        if (m_req && !ack) begin
        end else if (v && flt) begin
            m_req = 1'b1; m_ea = ea;
        end else begin
            m_req = 1'b0;
        end
        e.req = m_req; e.ea = m_ea; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic clear();
        drive(1'b0, 3'd0, '0, 2'd2, 7'd0, 1'b1, 1'b0, "ack");
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            logic [VW-1:0] ev;
            e = q.pop_front();
            ev = e.req ? 12'h600 : 12'h000;
            n_cmp++;
            if (exc_req !== e.req || exc_vec !== ev || (e.req && exc_ea !== e.ea)) begin
                n_bad++;
                $display("FAIL %s: req=%0b vec=%h ea=%h expected req=%0b vec=%h ea=%h",
                         e.tag, exc_req, exc_vec, exc_ea, e.req, ev, e.ea);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        n_cmp++;
        if (exc_req !== 1'b0 || exc_vec !== 12'h000 || exc_ea !== '0) begin
            n_bad++;
            $display("FAIL R1: req=%0b vec=%h ea=%h expected 0/000/0", exc_req, exc_vec, exc_ea);
        end
        rst_n = 1'b1;
        drive(1'b0, 3'd0, '0, 2'd2, 7'd0, 1'b0, 1'b0, "R1 idle");
        // R2 floating point
        drive(1'b1, 3'd1, 32'h1000, 2'd2, 7'd0, 1'b0, 1'b0, "R2 aligned");
        drive(1'b1, 3'd1, 32'h1002, 2'd2, 7'd0, 1'b0, 1'b1, "R2 misaligned"); clear();
        drive(1'b1, 3'd1, 32'h1004, 2'd2, 7'b0010000, 1'b0, 1'b1, "R2 direct store"); clear();
        // R3 multiple and reservation
        drive(1'b1, 3'd2, 32'h2001, 2'd2, 7'd0, 1'b0, 1'b1, "R3 multi"); clear();
        drive(1'b1, 3'd4, 32'h3004, 2'd2, 7'd0, 1'b0, 1'b0, "R3 reserve aligned");
        drive(1'b1, 3'd4, 32'h3006, 2'd2, 7'd0, 1'b0, 1'b1, "R3 reserve misaligned"); clear();
        // R4 segment crossing
        drive(1'b1, 3'd0, 32'h4000, 2'd2, 7'b0100000, 1'b0, 1'b1, "R4 plain"); clear();
        drive(1'b1, 3'd3, 32'h4010, 2'd2, 7'b0100000, 1'b0, 1'b1, "R4 string"); clear();
        drive(1'b1, 3'd4, 32'h4020, 2'd2, 7'b0100000, 1'b0, 1'b0, "R4 reserve unaffected");
        // R5 block zero
        drive(1'b1, 3'd5, 32'h4100, 2'd2, 7'b0001000, 1'b0, 1'b1, "R5 wthru"); clear();
        drive(1'b1, 3'd5, 32'h4200, 2'd2, 7'b0000100, 1'b0, 1'b1, "R5 cinhib"); clear();
        drive(1'b1, 3'd5, 32'h4300, 2'd2, 7'b0000010, 1'b0, 1'b1, "R5 dc absent"); clear();
        drive(1'b1, 3'd5, 32'h4400, 2'd2, 7'b0000001, 1'b0, 1'b1, "R5 dc wthru"); clear();
        drive(1'b1, 3'd5, 32'h4503, 2'd2, 7'd0, 1'b0, 1'b0, "R5 clean");
        // R6 external control
        drive(1'b1, 3'd6, 32'h5002, 2'd2, 7'd0, 1'b0, 1'b1, "R6 word mis"); clear();
        drive(1'b1, 3'd6, 32'h5004, 2'd2, 7'd0, 1'b0, 1'b0, "R6 word ok");
        drive(1'b1, 3'd6, 32'h5001, 2'd1, 7'd0, 1'b0, 1'b1, "R6 half mis"); clear();
        drive(1'b1, 3'd6, 32'h5003, 2'd0, 7'd0, 1'b0, 1'b0, "R6 byte ok");
        drive(1'b1, 3'd6, 32'h5004, 2'd3, 7'd0, 1'b0, 1'b1, "R6 dword mis"); clear();
        // R7 little-endian multiple/string
        drive(1'b1, 3'd2, 32'h6000, 2'd2, 7'b1000000, 1'b0, 1'b1, "R7 multi"); clear();
        drive(1'b1, 3'd3, 32'h6100, 2'd2, 7'b1000000, 1'b0, 1'b1, "R7 string"); clear();
        // R8 tolerated misalignment
        drive(1'b1, 3'd0, 32'h6203, 2'd2, 7'b1000000, 1'b0, 1'b0, "R8 plain LE");
        drive(1'b1, 3'd0, 32'h6205, 2'd3, 7'd0, 1'b0, 1'b0, "R8 plain BE");
        drive(1'b1, 3'd3, 32'h6301, 2'd2, 7'd0, 1'b0, 1'b0, "R8 string BE");
        // R9/R10 hold, ignore, ack plus new fault
        drive(1'b1, 3'd4, 32'h7001, 2'd2, 7'd0, 1'b0, 1'b1, "R9 capture");
        drive(1'b1, 3'd1, 32'h7102, 2'd2, 7'd0, 1'b0, 1'b1, "R10 held");
        drive(1'b0, 3'd0, '0, 2'd2, 7'd0, 1'b0, 1'b0, "R10 held idle");
        drive(1'b1, 3'd2, 32'h7203, 2'd2, 7'd0, 1'b1, 1'b1, "R10 ack+new");
        clear();
        // R11 invalid op
        drive(1'b0, 3'd4, 32'h8001, 2'd2, 7'd0, 1'b0, 1'b1, "R11 invalid");
        drive(1'b0, 3'd0, '0, 2'd2, 7'd0, 1'b0, 1'b0, "R11 drain");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule